// File: doc/BRIEF.md
# Transmit/Receive Word FIFO Pair with Sticky Error Flags

This block holds the two data queues that sit between a system bus and one execution engine. The transmit queue is filled by bus writes and drained by the engine. The receive queue is filled by the engine and drained by bus reads. Each queue stores 32-bit words and is four entries deep. For each direction the block reports a full indication, an empty indication and a fill level.

Bus accesses never stall. A bus write that finds the transmit queue full is dropped. A bus read that finds the receive queue empty is also dropped. Neither one changes the queue, and each is logged in its own sticky debug flag. Software clears a flag by writing a one to that flag's bit.

A flush strobe empties both queues in one cycle. It leaves the debug flags alone, and it leaves everything outside the queues untouched. On the engine side, a pull from an empty transmit queue or a push into a full receive queue is ignored without raising a flag, because the engine is expected to wait on the full and empty outputs.

Top module: `xfer_fifo_pair`

## Requirements
- R1: Words leave each queue in the order they entered. The oldest transmit word is shown on `engPullData`, and the oldest receive word is shown on `busRdData`. Each accepted pull or read advances the queue on the next rising edge.
- R2: A bus write while `txFull` is high is dropped. The transmit level stays at 4 and the stored words are unchanged.
- R3: A bus write while `txFull` is high sets `dbgFlags[0]` (transmit overflow) after the next rising edge.
- R4: A bus read while `rxEmpty` is high is dropped, and the receive queue stays empty with a level of 0.
- R5: A bus read while `rxEmpty` is high sets `dbgFlags[1]` (receive underflow) after the next rising edge. The data returned by that read has no defined value.
- R6: `txLevel` and `rxLevel` give the stored word count (0 to 4). Full is high exactly at a level of 4 and empty exactly at 0. After reset both levels are 0 and both flags are 0.
- R7: `clearFifos` empties both queues at the next edge. It overrides any push, pull, bus write or bus read in the same cycle.
- R8: A set debug flag stays set until a cycle with `dbgClrWr` high and a one in the matching bit of `dbgClrData` (bit 0 for overflow, bit 1 for underflow). A zero bit leaves the flag as it is, and `clearFifos` does not clear flags. If a new error and a clearing write arrive in the same cycle, the flag ends up set.
- R9: An engine pull while the transmit queue is empty, or an engine push while the receive queue is full, changes no queue and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Bus write strobe into the transmit queue |
| busWrData | input | 32 | Bus write word |
| busRdEn | input | 1 | Bus read strobe from the receive queue |
| busRdData | output | 32 | Oldest receive word |
| engPull | input | 1 | Engine takes one word from the transmit queue |
| engPullData | output | 32 | Oldest transmit word |
| engPush | input | 1 | Engine stores one word into the receive queue |
| engPushData | input | 32 | Engine word to store |
| clearFifos | input | 1 | Flush both queues |
| dbgClrWr | input | 1 | Write strobe for the write-one-to-clear flag register |
| dbgClrData | input | 2 | Bits to clear: bit 0 overflow, bit 1 underflow |
| txFull | output | 1 | Transmit queue holds 4 words |
| txEmpty | output | 1 | Transmit queue holds no words |
| txLevel | output | 3 | Transmit word count |
| rxFull | output | 1 | Receive queue holds 4 words |
| rxEmpty | output | 1 | Receive queue holds no words |
| rxLevel | output | 3 | Receive word count |
| dbgFlags | output | 2 | Sticky flags: bit 0 overflow, bit 1 underflow |

## Verification
Two pairs of functions can fall in the same cycle. First, a flush can meet pushes, pulls and bus accesses. Second, the setting of a flag can meet its write-one-to-clear. The bench sweeps the transmit queue through each fill level from 0 to 3. At each level it raises `clearFifos` together with a bus write and an engine push, and it expects both levels to read 0 one edge later with the flags unchanged. It then raises a dropped bus write together with a clearing write of bit 0, and expects the overflow flag to remain set. It also runs all four `dbgClrData` patterns against two set flags and compares the result with the complement of each pattern.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
  // Strobes issued by the control module to the storage datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic flush;
  } fifoStrobes_t;
endpackage

// File: rtl/xfer_fifo_datapath.sv
module xfer_fifo_datapath
  import xfer_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [DATA_W-1:0] txWrData,
  input  logic [DATA_W-1:0] rxWrData,
  output logic [DATA_W-1:0] txHead,
  output logic [DATA_W-1:0] rxHead,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel
);
  // Index 0 is the transmit direction, index 1 the receive direction
  logic              pushV [2];
  logic              popV  [2];
  logic [DATA_W-1:0] inData [2];
  logic [DATA_W-1:0] headV [2];
  logic [LVL_W-1:0]  lvlV  [2];

  assign pushV[0]  = strobes.txPush;
  assign popV[0]   = strobes.txPop;
  assign inData[0] = txWrData;
  assign pushV[1]  = strobes.rxPush;
  assign popV[1]   = strobes.rxPop;
  assign inData[1] = rxWrData;

  for (genvar g = 0; g < 2; g++) begin : gDir
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wrPtr;
    logic [PTR_W-1:0]  rdPtr;
    logic [LVL_W-1:0]  count;

    function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else if (strobes.flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (pushV[g]) wrPtr <= nextPtr(wrPtr);
        if (popV[g])  rdPtr <= nextPtr(rdPtr);
        case ({pushV[g], popV[g]})
          2'b10:   count <= count + LVL_W'(1);
          2'b01:   count <= count - LVL_W'(1);
          default: count <= count;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (pushV[g] && !strobes.flush) mem[wrPtr] <= inData[g];
    end

    assign headV[g] = mem[rdPtr];
    assign lvlV[g]  = count;
  end

  assign txHead  = headV[0];
  assign rxHead  = headV[1];
  assign txLevel = lvlV[0];
  assign rxLevel = lvlV[1];
endmodule

// File: rtl/xfer_fifo_ctrl.sv
module xfer_fifo_ctrl
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic             engPull,
  input  logic             engPush,
  input  logic             clearFifos,
  input  logic             dbgClrWr,
  input  logic [1:0]       dbgClrData,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  output fifoStrobes_t     strobes,
  output logic             txFull,
  output logic             txEmpty,
  output logic             rxFull,
  output logic             rxEmpty,
  output logic [1:0]       dbgFlags
);
  logic overflowHit;
  logic underflowHit;
  logic [1:0] clrMask;

  assign txFull  = (txLevel == LVL_W'(DEPTH));
  assign txEmpty = (txLevel == '0);
  assign rxFull  = (rxLevel == LVL_W'(DEPTH));
  assign rxEmpty = (rxLevel == '0);

  always_comb begin
    strobes        = '0;
    strobes.flush  = clearFifos;
    strobes.txPush = busWrEn && !txFull  && !clearFifos;
    strobes.txPop  = engPull && !txEmpty && !clearFifos;
    strobes.rxPush = engPush && !rxFull  && !clearFifos;
    strobes.rxPop  = busRdEn && !rxEmpty && !clearFifos;
  end

  // Errors are judged on the queue state seen in the access cycle
  assign overflowHit  = busWrEn && txFull;
  assign underflowHit = busRdEn && rxEmpty;
  assign clrMask      = dbgClrWr ? dbgClrData : 2'b00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbgFlags <= '0;
    end else begin
      dbgFlags[0] <= (dbgFlags[0] && !clrMask[0]) || overflowHit;
      dbgFlags[1] <= (dbgFlags[1] && !clrMask[1]) || underflowHit;
    end
  end
endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair
  import xfer_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              engPull,
  output logic [DATA_W-1:0] engPullData,
  input  logic              engPush,
  input  logic [DATA_W-1:0] engPushData,
  input  logic              clearFifos,
  input  logic              dbgClrWr,
  input  logic [1:0]        dbgClrData,
  output logic              txFull,
  output logic              txEmpty,
  output logic [LVL_W-1:0]  txLevel,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic [LVL_W-1:0]  rxLevel,
  output logic [1:0]        dbgFlags
);
  fifoStrobes_t strobes;

  xfer_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .engPull    (engPull),
    .engPush    (engPush),
    .clearFifos (clearFifos),
    .dbgClrWr   (dbgClrWr),
    .dbgClrData (dbgClrData),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .strobes    (strobes),
    .txFull     (txFull),
    .txEmpty    (txEmpty),
    .rxFull     (rxFull),
    .rxEmpty    (rxEmpty),
    .dbgFlags   (dbgFlags)
  );

  xfer_fifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .txWrData (busWrData),
    .rxWrData (engPushData),
    .txHead   (engPullData),
    .rxHead   (busRdData),
    .txLevel  (txLevel),
    .rxLevel  (rxLevel)
  );
endmodule

// File: rtl/xfer_fifo_pair_chk.sv
module xfer_fifo_pair_chk #(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWrEn,
  input logic             busRdEn,
  input logic             engPull,
  input logic             engPush,
  input logic             clearFifos,
  input logic             dbgClrWr,
  input logic [1:0]       dbgClrData,
  input logic             txFull,
  input logic             txEmpty,
  input logic [LVL_W-1:0] txLevel,
  input logic             rxEmpty,
  input logic [LVL_W-1:0] rxLevel,
  input logic [1:0]       dbgFlags
);
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && txFull && !engPull && !clearFifos |=> txLevel == LVL_W'(DEPTH)); // R2
  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && txFull |=> dbgFlags[0]); // R3
  AST_EMPTY_READ_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && rxEmpty && !engPush |=> rxEmpty); // R4
  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && rxEmpty |=> dbgFlags[1]); // R5
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    txLevel <= LVL_W'(DEPTH) && rxLevel <= LVL_W'(DEPTH)); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    clearFifos |=> txLevel == '0 && rxLevel == '0); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    dbgFlags[0] && !(dbgClrWr && dbgClrData[0]) |=> dbgFlags[0]); // R8
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    dbgFlags[1] && !(dbgClrWr && dbgClrData[1]) |=> dbgFlags[1]); // R8
  AST_EMPTY_PULL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    engPull && txEmpty && !busWrEn |=> txEmpty); // R9
endmodule

bind xfer_fifo_pair xfer_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .engPull    (engPull),
  .engPush    (engPush),
  .clearFifos (clearFifos),
  .dbgClrWr   (dbgClrWr),
  .dbgClrData (dbgClrData),
  .txFull     (txFull),
  .txEmpty    (txEmpty),
  .txLevel    (txLevel),
  .rxEmpty    (rxEmpty),
  .rxLevel    (rxLevel),
  .dbgFlags   (dbgFlags)
);

// File: tb/xfer_fifo_pair_tb.sv
`timescale 1ns/1ps
module xfer_fifo_pair_tb;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 0, busRdEn = 0, engPull = 0, engPush = 0;
  logic        clearFifos = 0, dbgClrWr = 0;
  logic [1:0]  dbgClrData = '0;
  logic [31:0] busWrData = '0, engPushData = '0;
  logic [31:0] busRdData, engPullData;
  logic        txFull, txEmpty, rxFull, rxEmpty;
  logic [2:0]  txLevel, rxLevel;
  logic [1:0]  dbgFlags;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xfer_fifo_pair u_dut (.*);

  function automatic logic [31:0] pat(input int dir, input int k);
    return 32'h1000_0000 * (dir + 1) + 32'h0001_0003 * k + 32'h55;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    busWrEn = 0; busRdEn = 0; engPull = 0; engPush = 0;
    clearFifos = 0; dbgClrWr = 0; dbgClrData = '0;
  endtask

  task automatic flush();
    clearFifos = 1; tick();
  endtask

  task automatic clearFlags();
    dbgClrWr = 1; dbgClrData = 2'b11; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R6 reset state
    chk("R6 reset levels", {26'd0, txLevel, rxLevel}, 32'd0);
    chk("R6 reset empty/full", {28'd0, txEmpty, txFull, rxEmpty, rxFull}, 32'b1010);
    chk("R6 reset flags", {30'd0, dbgFlags}, 32'd0);

    // Transmit sweep over every fill level
    for (int n = 0; n <= DEPTH; n++) begin
      flush();
      for (int k = 0; k < n; k++) begin
        busWrEn = 1; busWrData = pat(0, k + n); tick();
      end
      chk("R6 tx level", {29'd0, txLevel}, n);
      chk("R6 tx full/empty", {30'd0, txFull, txEmpty}, {30'd0, n == DEPTH, n == 0});
      if (n == DEPTH) begin
        busWrEn = 1; busWrData = 32'hDEAD_BEEF; tick();
        chk("R2 tx level after dropped write", {29'd0, txLevel}, DEPTH);
        chk("R3 overflow flag", {31'd0, dbgFlags[0]}, 1);
      end else begin
        chk("R3 no overflow below full", {31'd0, dbgFlags[0]}, 0);
      end
      for (int k = 0; k < n; k++) begin
        chk("R1 R2 tx order", engPullData, pat(0, k + n));
        engPull = 1; tick();
      end
      chk("R1 tx drained", {31'd0, txEmpty}, 1);
      clearFlags();
    end

    // R9 engine pull on empty transmit queue
    engPull = 1; tick();
    chk("R9 pull on empty tx", {29'd0, txLevel}, 0);
    chk("R9 no flag on empty pull", {30'd0, dbgFlags}, 0);

    // Receive sweep over every fill level
    for (int n = 0; n <= DEPTH; n++) begin
      flush();
      for (int k = 0; k < n; k++) begin
        engPush = 1; engPushData = pat(1, k * 3 + n); tick();
      end
      chk("R6 rx level", {29'd0, rxLevel}, n);
      chk("R6 rx full/empty", {30'd0, rxFull, rxEmpty}, {30'd0, n == DEPTH, n == 0});
      if (n == DEPTH) begin
        engPush = 1; engPushData = 32'hBAD0_0BAD; tick();
        chk("R9 push on full rx", {29'd0, rxLevel}, DEPTH);
        chk("R9 no flag on full push", {30'd0, dbgFlags}, 0);
      end
      for (int k = 0; k < n; k++) begin
        chk("R1 rx order", busRdData, pat(1, k * 3 + n));
        busRdEn = 1; tick();
      end
      chk("R5 no underflow on legal reads", {31'd0, dbgFlags[1]}, 0);
      busRdEn = 1; tick();
      chk("R4 rx stays empty", {28'd0, rxEmpty, rxLevel}, 32'b1000);
      chk("R5 underflow flag", {31'd0, dbgFlags[1]}, 1);
      chk("R3 underflow leaves overflow clear", {31'd0, dbgFlags[0]}, 0);
      clearFlags();
    end

    // R4 dropped read must not disturb a later write sequence
    busRdEn = 1; tick();
    engPush = 1; engPushData = 32'h0000_1234; tick();
    chk("R4 rx level after dropped read", {29'd0, rxLevel}, 1);
    chk("R4 rx data after dropped read", busRdData, 32'h0000_1234);
    flush(); clearFlags();

    // R8 write-one-to-clear over all masks; tx held full, rx empty
    for (int k = 0; k < DEPTH; k++) begin
      busWrEn = 1; busWrData = pat(0, k); tick();
    end
    for (int v = 0; v < 4; v++) begin
      busWrEn = 1; busRdEn = 1; tick();
      chk("R8 both flags set", {30'd0, dbgFlags}, 3);
      dbgClrWr = 1; dbgClrData = v[1:0]; tick();
      chk("R8 w1c mask", {30'd0, dbgFlags}, {30'd0, ~v[1:0]});
      tick();
      chk("R8 flags hold idle", {30'd0, dbgFlags}, {30'd0, ~v[1:0]});
      clearFlags();
    end
    // R8 set beats clear in the same cycle
    busWrEn = 1; dbgClrWr = 1; dbgClrData = 2'b01; tick();
    chk("R8 set wins over clear", {30'd0, dbgFlags}, 1);
    chk("R2 contents kept", engPullData, pat(0, 0));
    // R8 flush does not touch flags
    flush();
    chk("R8 flush keeps flags", {30'd0, dbgFlags}, 1);
    clearFlags();

    // R7 flush against same-cycle traffic at each tx level
    for (int n = 0; n < DEPTH; n++) begin
      for (int k = 0; k < n; k++) begin
        busWrEn = 1; busWrData = pat(0, k); tick();
      end
      engPush = 1; engPushData = 32'h7777; tick();
      clearFifos = 1; busWrEn = 1; busWrData = 32'h0BAD; engPush = 1;
      engPushData = 32'h0BAD; engPull = 1; busRdEn = 1; tick();
      chk("R7 flush wins", {26'd0, txLevel, rxLevel}, 0);
      chk("R7 flush empties", {30'd0, txEmpty, rxEmpty}, 3);
      chk("R7 flags untouched by flush", {30'd0, dbgFlags}, 0);
    end
    // R7 queue usable after flush
    busWrEn = 1; busWrData = 32'hCAFE_0001; tick();
    chk("R7 tx after flush", engPullData, 32'hCAFE_0001);
    chk("R7 tx level after flush", {29'd0, txLevel}, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule